// File: doc/BRIEF.md
# Scoreboard Hazard Controller

This block is the central hazard bookkeeper for a small pipeline whose functional units may finish out of order. It receives one decoded instruction per cycle as an operation class, a destination register and two source registers. It holds the instruction at its input until a unit of the right class is free and no in-flight instruction will write the same destination. Once issued, it tells each unit when its operands may be read and when its result may be written back. The pool has five units: one integer unit, two multipliers, one adder and one divider.

Each check sits at its own point. Structural and output (write-after-write) conflicts stall issue. True (read-after-write) dependences delay the operand read. Anti (write-after-read) dependences delay write-back. All state is held in a per-unit table and a per-register producer table. The units themselves are outside the block. Each reports the end of its execution with a done pulse, and the block answers with start and write-grant pulses.

Top module: `sb_scoreboard`

## Requirements
- R1: A synchronous active-high reset empties every table. After reset, `in_ready` is high for every operation class and `start_o` and `wr_grant_o` are zero, whatever was in flight before the reset.
- R2: Class codes are 0 integer, 1 multiply, 2 add, 3 divide. Unit index 0 is the integer unit, 1 and 2 are the multipliers, 3 is the adder and 4 is the divider. An instruction takes the lowest-index free unit of its class. `in_ready` is low while no unit of the class is free, and an instruction is accepted only in a cycle with `in_valid` and `in_ready` both high, so issue stays in program order.
- R3: `in_ready` is low while any issued instruction that has not yet written back has the same nonzero destination as the input.
- R4: A unit reads its operands at the first clock edge at which neither source waits on a result from an earlier instruction. `start_o[u]` is high for exactly the one cycle after that edge.
- R5: A unit that has finished execution is not granted write-back while an earlier instruction still has a ready, unread source equal to its nonzero destination.
- R6: `done_i[u]` is taken only while unit u is executing. A done pulse to an idle unit causes no grant and no change of state.
- R7: At most one unit writes back per clock edge, the lowest index among the eligible units. The unit written back shows `wr_grant_o[u]` high for the one following cycle, and the other eligible units retry.
- R8: A write-back frees its unit and its destination register. In the cycle `wr_grant_o` shows the write, an instruction needing that unit or that destination may issue. An instruction issued in the same cycle as the write, and reading that register, treats the source as ready.
- R9: Register 0 is never pending. As a destination it never stalls issue, and as a source it never delays an operand read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Decoded instruction present |
| in_class | input | 2 | Operation class (0 int, 1 mul, 2 add, 3 div) |
| in_dst | input | REG_W | Destination register |
| in_src1 | input | REG_W | First source register |
| in_src2 | input | REG_W | Second source register |
| in_ready | output | 1 | Instruction accepted at this edge if valid |
| start_o | output | 5 | Per-unit pulse: operands read, execution begins |
| done_i | input | 5 | Per-unit pulse: execution finished |
| wr_grant_o | output | 5 | Per-unit pulse: result written back, unit freed |

## Verification
A producer entry left set in the register table shows as `in_ready` stuck low for every later writer of that register. A missed result broadcast leaves a consumer that never raises `start_o`. Both show at the ports within a cycle or two of the write that should have cleared them. A write-after-read check that is too loose gives a write grant one or more cycles before the earlier reader's `start_o`, and the stimulus table is built so that this ordering is visible cycle by cycle.

// File: rtl/sb_pkg.sv
package sb_pkg;
  localparam int N_INT     = 1;
  localparam int N_MUL     = 2;
  localparam int N_ADD     = 1;
  localparam int N_DIV     = 1;
  localparam int NUM_UNITS = N_INT + N_MUL + N_ADD + N_DIV;
  localparam int UID_W     = $clog2(NUM_UNITS);

  typedef enum logic [1:0] {
    CLS_INT = 2'd0, CLS_MUL = 2'd1, CLS_ADD = 2'd2, CLS_DIV = 2'd3
  } op_class_t;

  typedef enum logic [1:0] {
    PH_IDLE = 2'd0, PH_OPS = 2'd1, PH_EXEC = 2'd2, PH_WB = 2'd3
  } phase_t;

  // Class served by unit u; units are grouped by class in ascending order.
  function automatic logic [1:0] unit_class(input int u);
    if (u < N_INT)                      return CLS_INT;
    else if (u < N_INT + N_MUL)         return CLS_MUL;
    else if (u < N_INT + N_MUL + N_ADD) return CLS_ADD;
    else                                return CLS_DIV;
  endfunction
endpackage

// File: rtl/sb_reg_status.sv
// Per-register producer table: pending flag plus producing unit id.
module sb_reg_status #(
  parameter int RW = 5,
  parameter int UW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          set_en,
  input  logic [RW-1:0] set_idx,
  input  logic [UW-1:0] set_uid,
  input  logic          clr_en,
  input  logic [RW-1:0] clr_idx,
  input  logic [RW-1:0] probe_idx,
  output logic          probe_pend,
  input  logic [RW-1:0] rd_a_idx,
  output logic          rd_a_pend,
  output logic [UW-1:0] rd_a_uid,
  input  logic [RW-1:0] rd_b_idx,
  output logic          rd_b_pend,
  output logic [UW-1:0] rd_b_uid
);
  localparam int NREG = 1 << RW;

  logic [NREG-1:0] pend_q;
  logic [UW-1:0]   owner_q [NREG];

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q <= '0;
    end else begin
      if (clr_en) pend_q[clr_idx] <= 1'b0;
      if (set_en) pend_q[set_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (set_en) owner_q[set_idx] <= set_uid;
  end

  assign probe_pend = (probe_idx != '0) && pend_q[probe_idx];
  assign rd_a_pend  = (rd_a_idx  != '0) && pend_q[rd_a_idx];
  assign rd_b_pend  = (rd_b_idx  != '0) && pend_q[rd_b_idx];
  assign rd_a_uid   = owner_q[rd_a_idx];
  assign rd_b_uid   = owner_q[rd_b_idx];
endmodule

// File: rtl/sb_unit_slot.sv
// State of one functional unit: phase, registers, producer tags, ready flags.
module sb_unit_slot import sb_pkg::*; #(
  parameter int RW = 5,
  parameter int UW = 3
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          issue_en,
  input  logic [RW-1:0] i_dst,
  input  logic [RW-1:0] i_src1,
  input  logic [RW-1:0] i_src2,
  input  logic          i_q1v,
  input  logic [UW-1:0] i_q1,
  input  logic          i_q2v,
  input  logic [UW-1:0] i_q2,
  input  logic          bc_en,
  input  logic [UW-1:0] bc_uid,
  input  logic          done,
  input  logic          grant,
  output logic [1:0]    phase,
  output logic [RW-1:0] dst,
  output logic [RW-1:0] src1,
  output logic [RW-1:0] src2,
  output logic          rdy1,
  output logic          rdy2,
  output logic          read_go
);
  phase_t        ph_q;
  logic          q1v, q2v;
  logic [UW-1:0] q1, q2;
  logic          hit1, hit2;

  assign phase   = ph_q;
  assign read_go = (ph_q == PH_OPS) && rdy1 && rdy2;
  assign hit1    = bc_en && q1v && (q1 == bc_uid);
  assign hit2    = bc_en && q2v && (q2 == bc_uid);

  always_ff @(posedge clk) begin
    if (rst) begin
      ph_q <= PH_IDLE;
      rdy1 <= 1'b0;
      rdy2 <= 1'b0;
      q1v  <= 1'b0;
      q2v  <= 1'b0;
    end else begin
      unique case (ph_q)
        PH_IDLE: if (issue_en) begin
          ph_q <= PH_OPS;
          q1v  <= i_q1v;
          q2v  <= i_q2v;
          rdy1 <= !i_q1v;
          rdy2 <= !i_q2v;
        end
        PH_OPS: if (read_go) begin
          ph_q <= PH_EXEC;
          rdy1 <= 1'b0;
          rdy2 <= 1'b0;
        end else begin
          if (hit1) begin q1v <= 1'b0; rdy1 <= 1'b1; end
          if (hit2) begin q2v <= 1'b0; rdy2 <= 1'b1; end
        end
        PH_EXEC: if (done)  ph_q <= PH_WB;
        PH_WB:   if (grant) ph_q <= PH_IDLE;
        default: ph_q <= PH_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (issue_en) begin
      dst  <= i_dst;
      src1 <= i_src1;
      src2 <= i_src2;
      q1   <= i_q1;
      q2   <= i_q2;
    end
  end
endmodule

// File: rtl/sb_wr_arbiter.sv
// Fixed-priority pick of one write-back per cycle, lowest index first.
module sb_wr_arbiter #(
  parameter int N  = 5,
  parameter int UW = 3
) (
  input  logic [N-1:0]  req,
  output logic [N-1:0]  gnt,
  output logic [UW-1:0] gnt_uid,
  output logic          gnt_any
);
  always_comb begin
    gnt     = '0;
    gnt_uid = '0;
    gnt_any = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (req[i] && !gnt_any) begin
        gnt[i]  = 1'b1;
        gnt_uid = UW'(i);
        gnt_any = 1'b1;
      end
    end
  end
endmodule

// File: rtl/sb_scoreboard.sv
module sb_scoreboard import sb_pkg::*; #(
  parameter int REG_W = 5
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 in_valid,
  input  logic [1:0]           in_class,
  input  logic [REG_W-1:0]     in_dst,
  input  logic [REG_W-1:0]     in_src1,
  input  logic [REG_W-1:0]     in_src2,
  output logic                 in_ready,
  output logic [NUM_UNITS-1:0] start_o,
  input  logic [NUM_UNITS-1:0] done_i,
  output logic [NUM_UNITS-1:0] wr_grant_o
);
  localparam int NU = NUM_UNITS;
  localparam int UW = UID_W;

  logic [NU-1:0][1:0]       ph;
  logic [NU-1:0][REG_W-1:0] u_dst, u_s1, u_s2;
  logic [NU-1:0]            u_r1, u_r2, u_read;
  logic [NU-1:0]            issue_sel, war_block, wb_req, wr_gnt;
  logic [UW-1:0]            issue_uid, wr_uid, s1_uid, s2_uid;
  logic                     free_found, dst_pend, s1_pend, s2_pend;
  logic                     issue_fire, wr_any, s1_wait, s2_wait;

  // Issue: lowest free unit of the class, no structural or WAW conflict.
  always_comb begin
    issue_sel  = '0;
    issue_uid  = '0;
    free_found = 1'b0;
    for (int u = 0; u < NU; u++) begin
      if (!free_found && ph[u] == PH_IDLE && unit_class(u) == in_class) begin
        issue_sel[u] = 1'b1;
        issue_uid    = UW'(u);
        free_found   = 1'b1;
      end
    end
  end

  assign in_ready   = free_found && !dst_pend;
  assign issue_fire = in_valid && in_ready;
  // A producer writing back this very edge is already done for the new reader.
  assign s1_wait    = s1_pend && !(wr_any && s1_uid == wr_uid);
  assign s2_wait    = s2_pend && !(wr_any && s2_uid == wr_uid);

  sb_reg_status #(.RW(REG_W), .UW(UW)) regstat_i (
    .clk       (clk),
    .rst       (rst),
    .set_en    (issue_fire && in_dst != '0),
    .set_idx   (in_dst),
    .set_uid   (issue_uid),
    .clr_en    (wr_any && u_dst[wr_uid] != '0),
    .clr_idx   (u_dst[wr_uid]),
    .probe_idx (in_dst),
    .probe_pend(dst_pend),
    .rd_a_idx  (in_src1),
    .rd_a_pend (s1_pend),
    .rd_a_uid  (s1_uid),
    .rd_b_idx  (in_src2),
    .rd_b_pend (s2_pend),
    .rd_b_uid  (s2_uid)
  );

  for (genvar g = 0; g < NU; g++) begin : g_unit
    sb_unit_slot #(.RW(REG_W), .UW(UW)) slot_i (
      .clk     (clk),
      .rst     (rst),
      .issue_en(issue_fire && issue_sel[g]),
      .i_dst   (in_dst),
      .i_src1  (in_src1),
      .i_src2  (in_src2),
      .i_q1v   (s1_wait),
      .i_q1    (s1_uid),
      .i_q2v   (s2_wait),
      .i_q2    (s2_uid),
      .bc_en   (wr_any),
      .bc_uid  (wr_uid),
      .done    (done_i[g]),
      .grant   (wr_gnt[g]),
      .phase   (ph[g]),
      .dst     (u_dst[g]),
      .src1    (u_s1[g]),
      .src2    (u_s2[g]),
      .rdy1    (u_r1[g]),
      .rdy2    (u_r2[g]),
      .read_go (u_read[g])
    );
  end

  // WAR: hold a finished unit while another still needs the old value.
  always_comb begin
    war_block = '0;
    for (int u = 0; u < NU; u++) begin
      for (int f = 0; f < NU; f++) begin
        if (f != u && ph[f] == PH_OPS &&
            ((u_r1[f] && u_s1[f] == u_dst[u]) ||
             (u_r2[f] && u_s2[f] == u_dst[u])))
          war_block[u] = 1'b1;
      end
      wb_req[u] = (ph[u] == PH_WB) && (u_dst[u] == '0 || !war_block[u]);
    end
  end

  sb_wr_arbiter #(.N(NU), .UW(UW)) arb_i (
    .req    (wb_req),
    .gnt    (wr_gnt),
    .gnt_uid(wr_uid),
    .gnt_any(wr_any)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      start_o    <= '0;
      wr_grant_o <= '0;
    end else begin
      start_o    <= u_read;
      wr_grant_o <= wr_gnt;
    end
  end
endmodule

// File: rtl/sb_scoreboard_chk.sv
module sb_scoreboard_chk import sb_pkg::*; #(
  parameter int NU = 5,
  parameter int RW = 5
) (
  input logic                clk,
  input logic                rst,
  input logic                in_valid,
  input logic                in_ready,
  input logic [RW-1:0]       in_dst,
  input logic [NU-1:0]       start_o,
  input logic [NU-1:0]       wr_grant_o,
  input logic [NU-1:0][1:0]  ph,
  input logic [NU-1:0][RW-1:0] u_dst
);
  // R7: one write-back per edge
  a_r7_grant_onehot: assert property (@(posedge clk) disable iff (rst)
    $onehot0(wr_grant_o));

  for (genvar u = 0; u < NU; u++) begin : g_chk
    // R3: an accepted destination is not owned by a busy unit
    a_r3_no_waw_issue: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_ready && in_dst != '0 && ph[u] != PH_IDLE) |-> (u_dst[u] != in_dst));
    // R4: a start pulse follows an operand-wait phase
    a_r4_start_after_ops: assert property (@(posedge clk) disable iff (rst)
      start_o[u] |-> ($past(ph[u]) == PH_OPS && ph[u] == PH_EXEC));
    // R6: a grant only follows a finished execution
    a_r6_grant_from_wb: assert property (@(posedge clk) disable iff (rst)
      wr_grant_o[u] |-> ($past(ph[u]) == PH_WB));
    // R8: a granted unit is free in the grant cycle
    a_r8_free_on_grant: assert property (@(posedge clk) disable iff (rst)
      wr_grant_o[u] |-> (ph[u] == PH_IDLE));
  end
endmodule

bind sb_scoreboard sb_scoreboard_chk #(.NU(sb_pkg::NUM_UNITS), .RW(REG_W)) chk_i (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_dst    (in_dst),
  .start_o   (start_o),
  .wr_grant_o(wr_grant_o),
  .ph        (ph),
  .u_dst     (u_dst)
);

// File: tb/sb_scoreboard_tb.sv
`timescale 1ns/1ps
module sb_scoreboard_tb_top;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       in_valid = 1'b0;
  logic [1:0] in_class = 2'd0;
  logic [4:0] in_dst = '0, in_src1 = '0, in_src2 = '0;
  logic [4:0] done_i = '0;
  logic       in_ready;
  logic [4:0] start_o, wr_grant_o;
  int         n_tests = 0;
  int         n_fail  = 0;

  always #10 clk = ~clk;

  sb_scoreboard #(.REG_W(5)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_class(in_class),
    .in_dst(in_dst), .in_src1(in_src1), .in_src2(in_src2),
    .in_ready(in_ready), .start_o(start_o), .done_i(done_i),
    .wr_grant_o(wr_grant_o)
  );

  // {valid, class, dst, src1, src2, done, exp_ready, exp_start, exp_grant}
  localparam logic [33:0] VEC [14] = '{
    {1'b1, 2'd3, 5'd3, 5'd1, 5'd2, 5'b00000, 1'b1, 5'b00000, 5'b00000},
    {1'b1, 2'd2, 5'd4, 5'd3, 5'd5, 5'b00000, 1'b1, 5'b00000, 5'b00000},
    {1'b1, 2'd1, 5'd5, 5'd6, 5'd7, 5'b00000, 1'b1, 5'b10000, 5'b00000},
    {1'b1, 2'd1, 5'd3, 5'd8, 5'd9, 5'b00000, 1'b0, 5'b00000, 5'b00000},
    {1'b1, 2'd1, 5'd3, 5'd8, 5'd9, 5'b00010, 1'b0, 5'b00010, 5'b00000},
    {1'b1, 2'd1, 5'd3, 5'd8, 5'd9, 5'b00000, 1'b0, 5'b00000, 5'b00000},
    {1'b1, 2'd1, 5'd3, 5'd8, 5'd9, 5'b10000, 1'b0, 5'b00000, 5'b00000},
    {1'b1, 2'd1, 5'd3, 5'd8, 5'd9, 5'b00000, 1'b0, 5'b00000, 5'b00000},
    {1'b1, 2'd1, 5'd3, 5'd8, 5'd9, 5'b00000, 1'b1, 5'b00000, 5'b10000},
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b00000, 1'b1, 5'b01000, 5'b00000},
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b01100, 1'b1, 5'b00100, 5'b00010},
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b00000, 1'b1, 5'b00000, 5'b00000},
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b00000, 1'b1, 5'b00000, 5'b00100},
    {1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b00000, 1'b1, 5'b00000, 5'b01000}
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic step(input logic v, input logic [1:0] c, input logic [4:0] d,
                      input logic [4:0] s1, input logic [4:0] s2, input logic [4:0] dn);
    @(negedge clk);
    in_valid = v; in_class = c; in_dst = d; in_src1 = s1; in_src2 = s2; done_i = dn;
    #1;
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1; in_valid = 1'b0; done_i = '0;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  initial begin
    #(20 * 5000);
    n_fail++;
    $display("FAIL watchdog: actual hung expected finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    do_reset();
    // R1: reset state, every class issuable
    for (int c = 0; c < 4; c++) begin
      step(1'b0, 2'(c), 5'd1, 5'd0, 5'd0, 5'b0);
      chk($sformatf("R1 ready class %0d", c), 32'(in_ready), 32'd1);
    end
    chk("R1 start after reset", 32'(start_o), 32'd0);
    chk("R1 grant after reset", 32'(wr_grant_o), 32'd0);

    // Table: RAW wait, WAR hold, WAW stall, write tie (R2 R3 R4 R5 R7)
    for (int i = 0; i < 14; i++) begin
      logic [33:0] r;
      r = VEC[i];
      step(r[33], r[32:31], r[30:26], r[25:21], r[20:16], r[15:11]);
      chk($sformatf("row %0d R2 R3 in_ready", i), 32'(in_ready), 32'(r[10]));
      chk($sformatf("row %0d R4 start", i), 32'(start_o), 32'(r[9:5]));
      chk($sformatf("row %0d R5 R7 grant", i), 32'(wr_grant_o), 32'(r[4:0]));
    end

    // Register 0, structural stall, ignored done (R9 R2 R6 R8)
    do_reset();
    step(1'b1, 2'd1, 5'd0, 5'd1, 5'd2, 5'b0);
    chk("R2 first mul ready", 32'(in_ready), 32'd1);
    step(1'b1, 2'd1, 5'd0, 5'd0, 5'd0, 5'b0);
    chk("R9 dst r0 no WAW", 32'(in_ready), 32'd1);
    step(1'b1, 2'd1, 5'd7, 5'd1, 5'd1, 5'b0);
    chk("R2 both mul busy", 32'(in_ready), 32'd0);
    chk("R4 mul0 start", 32'(start_o), 32'b00010);
    step(1'b1, 2'd1, 5'd7, 5'd1, 5'd1, 5'b0);
    chk("R2 still stalled", 32'(in_ready), 32'd0);
    chk("R9 src r0 read at once", 32'(start_o), 32'b00100);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b00001);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
    chk("R6 idle done no grant", 32'(wr_grant_o), 32'd0);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b00110);
    chk("R6 idle done no grant later", 32'(wr_grant_o), 32'd0);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
    chk("R7 grant waits one edge", 32'(wr_grant_o), 32'd0);
    step(1'b1, 2'd1, 5'd7, 5'd1, 5'd1, 5'b0);
    chk("R7 mul0 granted first", 32'(wr_grant_o), 32'b00010);
    chk("R8 freed unit reusable", 32'(in_ready), 32'd1);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
    chk("R7 mul1 granted next", 32'(wr_grant_o), 32'b00100);

    // Issue while producer writes back (R8)
    do_reset();
    step(1'b1, 2'd3, 5'd10, 5'd1, 5'd2, 5'b0);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b10000);
    chk("R4 div start", 32'(start_o), 32'b10000);
    step(1'b1, 2'd2, 5'd11, 5'd10, 5'd0, 5'b0);
    chk("R8 issue during write", 32'(in_ready), 32'd1);
    step(1'b1, 2'd3, 5'd10, 5'd1, 5'd1, 5'b0);
    chk("R8 div grant", 32'(wr_grant_o), 32'b10000);
    chk("R8 dst and unit freed", 32'(in_ready), 32'd1);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
    chk("R8 consumer reads next edge", 32'(start_o), 32'b01000);
    step(1'b0, 2'd0, 5'd0, 5'd0, 5'd0, 5'b0);
    chk("R4 reissued div start", 32'(start_o), 32'b10000);

    // Reset with work in flight (R1)
    do_reset();
    step(1'b0, 2'd3, 5'd10, 5'd0, 5'd0, 5'b0);
    chk("R1 div and r10 free after reset", 32'(in_ready), 32'd1);
    chk("R1 start cleared", 32'(start_o), 32'd0);
    chk("R1 grant cleared", 32'(wr_grant_o), 32'd0);

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule